// File: doc/BRIEF.md
# Multi-Policy Cache Victim Selector

This block keeps the replacement bookkeeping for every set of an N-way set-associative cache. For the set being addressed, it names the way that a new line should fill. A compile-time parameter selects the policy: exact least-recently-used (LRU), first-in-first-out (FIFO), or pseudorandom. Tags, data arrays, write-back of dirty lines and the memory side all belong to the surrounding cache.

In each cycle the cache presents the following:
- an access strobe;
- the set index;
- a hit flag and the way that hit;
- the valid bits of all ways in that set;
- a fill-commit strobe, raised when a miss is really allocated.

The victim output is combinational from these inputs and from the stored state. On the next rising clock edge, the stored state absorbs the hit or the committed fill.

Free ways always come first. While the addressed set still has an invalid way, the block returns that way and the policy state plays no part in the choice. Each policy reacts to a different event:
- LRU reorders on every hit and on every committed fill.
- FIFO moves only when a full set really evicts.
- Random steps one shared shift register every cycle.

Top module: `victim_sel`

## Requirements
- R1: When any bit of `acc_valid_ways` is 0, `victim_way` is the lowest index whose valid bit is 0. This holds under every policy.
- R2: In LRU mode each set holds a rank per way, with 0 meaning most recent. On a touch, the touched way becomes 0 and every way whose rank was below the touched way's old rank goes up by one. When the set is full, the victim is the way ranked NUM_WAYS-1.
- R3: In LRU mode a hit (`acc_vld`=1, `acc_hit`=1) touches `acc_hit_way`. A committed fill touches the way that was reported as victim in that cycle.
- R4: In FIFO mode each set keeps one pointer, and that pointer is the victim of a full set. A committed fill into a full set advances the pointer by one, wrapping from NUM_WAYS-1 to 0.
- R5: In FIFO mode, hits and committed fills into a set that still has a free way leave the pointer unchanged.
- R6: Random mode uses one 16-bit shift register shared by all sets. On each clock, it shifts left and the bit shifted in is bit15 xor bit13 xor bit12 xor bit10. The victim of a full set is the register's low log2(NUM_WAYS) bits, taken modulo NUM_WAYS.
- R7: After a cycle with `rst_n`=0, the following reset state holds:
  - In every set, way w has LRU rank w, so the full-set victim is way NUM_WAYS-1.
  - Every FIFO pointer is 0.
  - The shift register holds 16'hACE1.
- R8: When NUM_WAYS=1, `victim_way` is always 0.
- R9: `fill_commit` has no effect unless the same cycle has `acc_vld`=1 and `acc_hit`=0.
- R10: A hit or fill in one set changes the victim of no other set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_vld | input | 1 | Access strobe for the addressed set |
| acc_set | input | SET_W | Set index of the access |
| acc_hit | input | 1 | The access hit a resident line |
| acc_hit_way | input | WAY_W | Way that hit, used when `acc_hit`=1 |
| acc_valid_ways | input | NUM_WAYS | Valid bit of each way in the addressed set |
| fill_commit | input | 1 | A miss in this cycle is allocated into `victim_way` |
| victim_way | output | WAY_W | Way to fill for the addressed set |

## Verification
The assertions assume two things about the inputs: `acc_hit_way` is below NUM_WAYS whenever a hit is flagged, and `acc_set` is below NUM_SETS. Under these assumptions, the LRU ranks of a set stay a permutation and exactly one way carries the top rank. The stimulus flags hits only on ways whose valid bit is set, and it only addresses sets that exist. It raises `fill_commit` on misses, and also deliberately together with hits and without any access, to show that those cases are ignored.

// File: rtl/vs_pkg.sv
// Package: shared policy encoding and constants for the victim selector.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package vs_pkg;

    typedef enum logic [1:0] {
        VS_LRU  = 2'd0,
        VS_FIFO = 2'd1,
        VS_RAND = 2'd2
    } vs_policy_e;

    localparam int          VS_LFSR_W    = 16;
    localparam logic [15:0] VS_LFSR_SEED = 16'hACE1;

endpackage

// File: rtl/vs_free_pick.sv
// vs_free_pick: finds the lowest-index invalid way of the addressed set.
// Assumes: valid_ways holds one bit per way; bit w set means way w is occupied.
module vs_free_pick #(
    parameter int NUM_WAYS = 4,
    parameter int WAY_W    = 2
) (
    input  logic [NUM_WAYS-1:0] valid_ways,
    output logic                any_free,
    output logic [WAY_W-1:0]    free_way
);

    // Priority scan from the top down, so the lowest free way wins.
    always_comb begin
        any_free = 1'b0;
        free_way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (!valid_ways[w]) begin
                any_free = 1'b1;
                free_way = WAY_W'(w);
            end
        end
    end

endmodule

// File: rtl/vs_lru_state.sv
// vs_lru_state: exact LRU ranks per set, with 0 = most recent and NUM_WAYS-1 = victim.
// Assumes: touch_way < NUM_WAYS; ranks of one set always form a permutation.
module vs_lru_state #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter int SET_W    = 4,
    parameter int WAY_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [SET_W-1:0] set_idx,
    input  logic [WAY_W-1:0] touch_way,
    output logic [WAY_W-1:0] lru_way
);

    localparam logic [WAY_W-1:0] TOP_RANK = WAY_W'(NUM_WAYS - 1);

    logic [NUM_SETS-1:0][NUM_WAYS-1:0][WAY_W-1:0] rank_q;
    logic [WAY_W-1:0]    old_rank;
    logic [NUM_WAYS-1:0] top_hit;

    // Rank the touched way held before this access.
    always_comb old_rank = rank_q[set_idx][touch_way];

    // Locate the way holding the top rank in the addressed set.
    always_comb begin
        lru_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            top_hit[w] = (rank_q[set_idx][w] == TOP_RANK);
            if (top_hit[w]) lru_way = WAY_W'(w);
        end
    end

    // Load a permutation at reset; age the younger ways and promote the touched way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++)
                for (int w = 0; w < NUM_WAYS; w++)
                    rank_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    rank_q[set_idx][w] <= '0;
                else if (rank_q[set_idx][w] < old_rank)
                    rank_q[set_idx][w] <= rank_q[set_idx][w] + 1'b1;
            end
        end
    end

    // R2: exactly one way of the addressed set carries the victim rank.
    p_single_victim_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(top_hit) == 1);

    // R2: after a touch, the touched way is the most recent in its set.
    p_touch_is_mru_r2: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |=> rank_q[$past(set_idx)][$past(touch_way)] == '0);

    // R10: the ranks are frozen when no touch is requested.
    p_rank_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !touch_en |=> $stable(rank_q));

endmodule

// File: rtl/vs_fifo_state.sv
// vs_fifo_state: one circular insertion pointer per set; the pointer is the next victim.
// Assumes: adv_en is raised only for a committed fill into a full set.
module vs_fifo_state #(
    parameter int NUM_SETS = 16,
    parameter int NUM_WAYS = 4,
    parameter int SET_W    = 4,
    parameter int WAY_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv_en,
    input  logic [SET_W-1:0] set_idx,
    output logic [WAY_W-1:0] fifo_way
);

    localparam logic [WAY_W-1:0] LAST_WAY = WAY_W'(NUM_WAYS - 1);

    logic [NUM_SETS-1:0][WAY_W-1:0] ptr_q;

    // Report the pointer of the addressed set.
    always_comb fifo_way = ptr_q[set_idx];

    // Clear all pointers at reset; step the addressed pointer modulo NUM_WAYS on eviction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (adv_en) begin
            ptr_q[set_idx] <= (ptr_q[set_idx] == LAST_WAY) ? '0 : ptr_q[set_idx] + 1'b1;
        end
    end

    // R4: an eviction moves the pointer of that set on by one, with wrap.
    p_ptr_advance_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |=> ptr_q[$past(set_idx)] ==
            (($past(fifo_way) == LAST_WAY) ? '0 : $past(fifo_way) + 1'b1));

    // R5: without an eviction, no pointer moves.
    p_ptr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !adv_en |=> $stable(ptr_q));

endmodule

// File: rtl/vs_lfsr.sv
// vs_lfsr: free-running 16-bit Fibonacci shift register shared by all sets.
// Assumes: the seed is nonzero, so the register never locks at zero.
module vs_lfsr (
    input  logic        clk,
    input  logic        rst_n,
    output logic [15:0] lfsr
);

    logic [15:0] lfsr_q;
    logic        fb;

    // Feedback taps at bits 15, 13, 12 and 10.
    always_comb fb = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

    // Load the seed at reset, then shift every cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= vs_pkg::VS_LFSR_SEED;
        else        lfsr_q <= {lfsr_q[14:0], fb};
    end

    assign lfsr = lfsr_q;

    // R6: the register never reaches the all-zero lock state.
    p_lfsr_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);

    // R6: the register changes on every clock outside reset.
    p_lfsr_steps_r6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> lfsr_q != $past(lfsr_q));

endmodule

// File: rtl/victim_sel.sv
// victim_sel: names the way to fill for the addressed set under LRU, FIFO or random policy.
// Assumes: acc_set < NUM_SETS; acc_hit_way < NUM_WAYS when acc_hit is set;
//          fill_commit counts only alongside a missing access in the same cycle.
module victim_sel #(
    parameter vs_pkg::vs_policy_e POLICY   = vs_pkg::VS_LRU,
    parameter int                 NUM_WAYS = 4,
    parameter int                 NUM_SETS = 16,
    localparam int                WAY_W    = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
    localparam int                SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_vld,
    input  logic [SET_W-1:0]    acc_set,
    input  logic                acc_hit,
    input  logic [WAY_W-1:0]    acc_hit_way,
    input  logic [NUM_WAYS-1:0] acc_valid_ways,
    input  logic                fill_commit,
    output logic [WAY_W-1:0]    victim_way
);

    logic             any_free;
    logic [WAY_W-1:0] free_way;
    logic [WAY_W-1:0] policy_way;
    logic             hit_evt;
    logic             fill_evt;
    logic             evict_evt;

    vs_free_pick #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_free (
        .valid_ways (acc_valid_ways),
        .any_free   (any_free),
        .free_way   (free_way)
    );

    // Qualify the strobes: a fill counts only on a missing access.
    always_comb begin
        hit_evt   = acc_vld && acc_hit;
        fill_evt  = acc_vld && !acc_hit && fill_commit;
        evict_evt = fill_evt && !any_free;
    end

    // Free ways take priority over the policy's choice.
    always_comb victim_way = any_free ? free_way : policy_way;

    generate
        if (NUM_WAYS == 1) begin : g_single
            assign policy_way = '0;
        end else if (POLICY == vs_pkg::VS_LRU) begin : g_lru
            logic             touch_en;
            logic [WAY_W-1:0] touch_way;

            // A hit touches the hit way; a committed fill touches the way it filled.
            always_comb begin
                touch_en  = hit_evt || fill_evt;
                touch_way = acc_hit ? acc_hit_way : victim_way;
            end

            vs_lru_state #(
                .NUM_SETS (NUM_SETS),
                .NUM_WAYS (NUM_WAYS),
                .SET_W    (SET_W),
                .WAY_W    (WAY_W)
            ) u_lru (
                .clk       (clk),
                .rst_n     (rst_n),
                .touch_en  (touch_en),
                .set_idx   (acc_set),
                .touch_way (touch_way),
                .lru_way   (policy_way)
            );
        end else if (POLICY == vs_pkg::VS_FIFO) begin : g_fifo
            vs_fifo_state #(
                .NUM_SETS (NUM_SETS),
                .NUM_WAYS (NUM_WAYS),
                .SET_W    (SET_W),
                .WAY_W    (WAY_W)
            ) u_fifo (
                .clk      (clk),
                .rst_n    (rst_n),
                .adv_en   (evict_evt),
                .set_idx  (acc_set),
                .fifo_way (policy_way)
            );
        end else begin : g_rand
            logic [15:0] lfsr;

            vs_lfsr u_lfsr (
                .clk   (clk),
                .rst_n (rst_n),
                .lfsr  (lfsr)
            );

            // Fold the low bits into the way range.
            always_comb policy_way = WAY_W'(lfsr[WAY_W-1:0] % NUM_WAYS);
        end
    endgenerate

    // R1: with a free way present, the chosen way is never an occupied one.
    p_free_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_vld && !(&acc_valid_ways)) |-> !acc_valid_ways[victim_way]);

endmodule

// File: tb/tb_victim_sel.sv
// tb_victim_sel: scoreboard bench driving four instances (LRU, FIFO, random, 1-way) in lockstep.
module tb_victim_sel;
    import vs_pkg::*;

    localparam int PERIOD = 10;
    localparam int NW     = 4;
    localparam int NS     = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_vld = 1'b0;
    logic [1:0] acc_set = '0;
    logic       acc_hit = 1'b0;
    logic [1:0] acc_hit_way = '0;
    logic [3:0] acc_valid_ways = 4'hF;
    logic       fill_commit = 1'b0;
    logic [1:0] v_lru, v_fifo, v_rand;
    logic       v_dm;

    always #(PERIOD / 2) clk = ~clk;

    victim_sel #(.POLICY(VS_LRU), .NUM_WAYS(NW), .NUM_SETS(NS)) dut (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_hit_way(acc_hit_way), .acc_valid_ways(acc_valid_ways),
        .fill_commit(fill_commit), .victim_way(v_lru));

    victim_sel #(.POLICY(VS_FIFO), .NUM_WAYS(NW), .NUM_SETS(NS)) dut_fifo (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_hit_way(acc_hit_way), .acc_valid_ways(acc_valid_ways),
        .fill_commit(fill_commit), .victim_way(v_fifo));

    victim_sel #(.POLICY(VS_RAND), .NUM_WAYS(NW), .NUM_SETS(NS)) dut_rand (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_hit_way(acc_hit_way), .acc_valid_ways(acc_valid_ways),
        .fill_commit(fill_commit), .victim_way(v_rand));

    victim_sel #(.POLICY(VS_LRU), .NUM_WAYS(1), .NUM_SETS(NS)) dut_dm (
        .clk(clk), .rst_n(rst_n), .acc_vld(acc_vld), .acc_set(acc_set),
        .acc_hit(acc_hit), .acc_hit_way(1'b0), .acc_valid_ways(acc_valid_ways[0]),
        .fill_commit(fill_commit), .victim_way(v_dm));

    typedef struct {
        string tag;
        int    e_lru;
        int    e_fifo;
        int    e_rand;
    } exp_t;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Reference model state, built from the requirements.
    int          m_rank[NS][NW];
    int          m_ptr[NS];
    logic [15:0] m_lf;

    task automatic model_reset();
        for (int s = 0; s < NS; s++) begin
            for (int w = 0; w < NW; w++) m_rank[s][w] = w;
            m_ptr[s] = 0;
        end
        m_lf = 16'hACE1;
    endtask

    task automatic model_touch(input int s, input int w);
        int old;
        old = m_rank[s][w];
        for (int i = 0; i < NW; i++) begin
            if (i == w) m_rank[s][i] = 0;
            else if (m_rank[s][i] < old) m_rank[s][i] = m_rank[s][i] + 1;
        end
    endtask

    // Driver: apply one cycle of stimulus, push the expected victims, advance the model.
    task automatic step(input logic r, input logic v, input int s, input logic h,
                        input int hw, input logic [3:0] vw, input logic f, input string tag);
        exp_t it;
        int   fw;
        int   lv;
        @(negedge clk);
        rst_n = r; acc_vld = v; acc_set = 2'(s); acc_hit = h;
        acc_hit_way = 2'(hw); acc_valid_ways = vw; fill_commit = f;
        fw = -1;
        for (int i = NW - 1; i >= 0; i--) if (!vw[i]) fw = i;
        lv = 0;
        for (int i = 0; i < NW; i++) if (m_rank[s][i] == NW - 1) lv = i;
        it.tag    = tag;
        it.e_lru  = (fw >= 0) ? fw : lv;
        it.e_fifo = (fw >= 0) ? fw : m_ptr[s];
        it.e_rand = (fw >= 0) ? fw : int'(m_lf[1:0]);
        q.push_back(it);
        if (!r) begin
            model_reset();
        end else begin
            m_lf = {m_lf[14:0], m_lf[15] ^ m_lf[13] ^ m_lf[12] ^ m_lf[10]};
            if (v && h) model_touch(s, hw);
            if (v && !h && f) begin
                model_touch(s, it.e_lru);
                if (fw < 0) m_ptr[s] = (m_ptr[s] + 1) % NW;
            end
        end
    endtask

    task automatic cmp(input string tag, input string what, input int got, input int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    // Monitor: a quarter period after each falling edge, compare outputs with the queue.
    initial begin
        exp_t it;
        forever begin
            @(negedge clk);
            #(PERIOD / 4);
            while (q.size() > 0) begin
                it = q.pop_front();
                cmp(it.tag, "lru",  int'(v_lru),  it.e_lru);
                cmp(it.tag, "fifo", int'(v_fifo), it.e_fifo);
                cmp(it.tag, "rand", int'(v_rand), it.e_rand);
                cmp("R8", "one-way", int'(v_dm), 0);
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
    end

    initial begin
        model_reset();
        // R7: reset state, during and right after reset.
        step(0, 0, 0, 0, 0, 4'hF, 0, "R7 in reset");
        step(0, 0, 0, 0, 0, 4'hF, 0, "R7 in reset");
        step(1, 0, 0, 0, 0, 4'hF, 0, "R7 after reset");
        // R1, R5: fill set 0 through its free ways; the FIFO pointer must stay put.
        step(1, 1, 0, 0, 0, 4'b0000, 1, "R1 R5 fill way0");
        step(1, 1, 0, 0, 0, 4'b0001, 1, "R1 R5 fill way1");
        step(1, 1, 0, 0, 0, 4'b0011, 1, "R1 R5 fill way2");
        step(1, 1, 0, 0, 0, 4'b0111, 1, "R1 R5 fill way3");
        step(1, 0, 0, 0, 0, 4'b0101, 0, "R1 lowest free");
        step(1, 0, 0, 0, 0, 4'b1011, 0, "R1 lowest free");
        step(1, 0, 0, 0, 0, 4'hF,    0, "R2 R5 full after fills");
        // R3, R5: a hit reorders LRU but leaves FIFO alone.
        step(1, 1, 0, 1, 0, 4'hF, 0, "R3 R5 hit way0");
        // R2, R4: evictions in a full set, with the FIFO pointer wrapping.
        for (int k = 0; k < 6; k++) step(1, 1, 0, 0, 0, 4'hF, 1, "R2 R4 evict");
        // R9: fill_commit with a hit, or with no access, is ignored.
        step(1, 1, 0, 1, 2, 4'hF, 1, "R9 fill with hit");
        step(1, 0, 0, 0, 0, 4'hF, 1, "R9 fill without access");
        step(1, 0, 0, 0, 0, 4'hF, 0, "R9 after ignored fills");
        // R10: an untouched set keeps its reset victims.
        step(1, 0, 2, 0, 0, 4'hF, 0, "R10 untouched set");
        // R3: hits in set 1 in descending order leave way 3 least recent.
        for (int w = 3; w >= 0; w--) step(1, 1, 1, 1, w, 4'hF, 0, "R3 hit order");
        step(1, 0, 1, 0, 0, 4'hF, 0, "R3 after hits");
        step(1, 0, 0, 0, 0, 4'hF, 0, "R10 set0 kept");
        // R6: the random victim follows the shift register each cycle.
        for (int k = 0; k < 40; k++) step(1, 0, 3, 0, 0, 4'hF, 0, "R6 random draw");
        // R7: a mid-run reset restores the initial state.
        step(0, 0, 0, 0, 0, 4'hF, 0, "R7 reset again");
        step(1, 0, 0, 0, 0, 4'hF, 0, "R7 after second reset");
        // R4: evictions in set 1 after the second reset.
        for (int k = 0; k < 5; k++) step(1, 1, 1, 0, 0, 4'hF, 1, "R4 evict set1");
        step(1, 0, 1, 0, 0, 4'hF, 0, "R4 after wrap");
        @(negedge clk);
        @(negedge clk);
        report();
    end

endmodule